// File: doc/BRIEF.md
# PWM Cycle Clock and Sync Unit

This unit derives the switching-cycle timing of a fixed-frequency PWM controller from a fast system clock. An internal counter runs over a programmable period, counted in system-clock cycles, and marks each cycle start with a one-cycle strobe. Halfway through every cycle the unit drives a short pulse onto a shared sync line. A second unit on the same line can then switch in antiphase.

The unit also watches the shared line. When pulses arrive there at a faster rate than its own, it becomes a slave: it releases its line driver and restarts its cycle on every accepted pulse. Two units wired to one line therefore settle on their own. The faster one stays master, and the slower one follows at the master's rate, offset by half a master period. The line is modelled as separate input, output and output-enable signals. The default parameters assume a 250 MHz system clock: 1000 cycles is the default rate (250 kHz), and 250 cycles is the fastest allowed rate (1 MHz).

Top module: `pwmsync_clk_unit`

## Requirements
- R1: During and right after reset: `cycle_start` = 0, `sync_out` = 0, `sync_oe` = 1, `slave_mode` = 0, and the period register holds DEF_PERIOD (1000 cycles).
- R2: In master mode, `cycle_start` is a one-cycle strobe repeating every P system cycles, where P is the period register.
- R3: In master mode, `sync_out` rises floor(P/2) cycles after the cycle in which `cycle_start` is high and stays high for OUT_PW (28) cycles. `sync_oe` is 1.
- R4: A one-cycle `period_load` writes `period_in` into the period register, clamped to [MIN_PERIOD, DEF_PERIOD] = [250, 1000]. For example, 400 gives 400, 100 gives 250, and 3000 gives 1000.
- R5: An accepted line pulse whose interval since the previous accepted pulse is strictly less than P puts the unit in slave mode and restarts its cycle. `cycle_start` is high IN_MIN_PW+2 (20) cycles after the first cycle in which `sync_in` is high, so a steady faster train gives a `cycle_start` spacing equal to the train's interval.
- R6: A pulse train slower than the unit's own rate is ignored: the unit stays master and the `cycle_start` spacing stays P.
- R7: In slave mode, `sync_oe` = 0 and `sync_out` = 0. When no accepted pulse arrives for P cycles, the unit returns to master mode and resumes spacing P.
- R8: A line pulse is accepted only if `sync_in` stays high for at least IN_MIN_PW (18) consecutive cycles. A train of 17-cycle pulses is ignored; 18-cycle pulses are accepted.
- R9: A line pulse whose rising edge is seen while the unit drives its own sync pulse is ignored and does not count as a reference for the rate comparison. An external pulse 300 cycles after the unit's own pulse, with no other pulse in the prior period, leaves it master.
- R10: Two units share one line, with periods 1000 and 500. The 500-cycle unit stays master, and the other becomes slave with spacing 500. Its `cycle_start` is 250+20 = 270 cycles after the master's `cycle_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_in | input | PIN_W (12) | Requested period in system cycles |
| period_load | input | 1 | One-cycle write strobe for the period register |
| sync_in | input | 1 | Level of the shared sync line (asynchronous) |
| sync_out | output | 1 | Sync pulse value to drive onto the line |
| sync_oe | output | 1 | Line driver enable, low in slave mode |
| cycle_start | output | 1 | One-cycle strobe at each PWM cycle start |
| slave_mode | output | 1 | High while locked to an external faster train |

## Verification
The assertions check the following on every cycle: each cycle-start strobe coincides with a counter value of zero, the own pulse rises exactly at the half count, the period register never leaves its clamp range, an accepted external pulse always restarts the cycle, slave mode is only entered through an acceptance, and the driver is silent while in slave mode. The rate comparison itself can only be shown by bench scenarios over several cycles. These scenarios cover takeover by a faster train, indifference to slower and narrow trains, rejection of a pulse that lands during the unit's own drive, release after the external train stops, and the half-period phase between two units on one line.

// File: rtl/pwmsync_pkg.sv
`timescale 1ns/1ps
package pwmsync_pkg;

  // Limit a requested period to the supported span.
  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Count at which the mid-cycle sync pulse starts.
  function automatic int unsigned half_of(int unsigned p);
    return p / 2;
  endfunction

endpackage

// File: rtl/pwmsync_period_reg.sv
`timescale 1ns/1ps
module pwmsync_period_reg #(
  parameter int PIN_W      = 12,
  parameter int PER_W      = 10,
  parameter int DEF_PERIOD = 1000,
  parameter int MIN_PERIOD = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIN_W-1:0] period_in,
  output logic [PER_W-1:0] period_q
);
  import pwmsync_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)
      period_q <= PER_W'(DEF_PERIOD);
    else if (load)
      period_q <= PER_W'(clamp_u(32'(period_in), MIN_PERIOD, DEF_PERIOD));
  end
endmodule

// File: rtl/pwmsync_cycle_timer.sv
`timescale 1ns/1ps
module pwmsync_cycle_timer #(
  parameter int PER_W  = 10,
  parameter int OUT_PW = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_q,
  input  logic             ext_accept,
  input  logic             slave_mode,
  output logic [PER_W-1:0] cnt,
  output logic [PER_W-1:0] half,
  output logic             cycle_start,
  output logic             drive_active
);
  import pwmsync_pkg::*;
  localparam int PW_W = $clog2(OUT_PW + 1);

  logic [PER_W-1:0] cnt_nxt;
  logic             wrap;
  logic [PW_W-1:0]  sp_cnt;

  assign half    = PER_W'(half_of(32'(period_q)));
  assign wrap    = (cnt >= period_q - 1'b1);
  assign cnt_nxt = (ext_accept || wrap) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      cycle_start <= 1'b0;
    end else begin
      cnt         <= cnt_nxt;
      cycle_start <= ext_accept || wrap;
    end
  end

  // Mid-cycle pulse: loaded so that the first high cycle has cnt == half.
  always_ff @(posedge clk) begin
    if (!rst_n || slave_mode)
      sp_cnt <= '0;
    else if (cnt_nxt == half)
      sp_cnt <= PW_W'(OUT_PW);
    else if (sp_cnt != '0)
      sp_cnt <= sp_cnt - 1'b1;
  end

  assign drive_active = (sp_cnt != '0);
endmodule

// File: rtl/pwmsync_ext_detect.sv
`timescale 1ns/1ps
module pwmsync_ext_detect #(
  parameter int PER_W       = 10,
  parameter int IN_MIN_PW   = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             drive_active,
  input  logic [PER_W-1:0] period_q,
  output logic             ext_accept,
  output logic             slave_mode
);
  localparam int HW = $clog2(IN_MIN_PW + 1);
  localparam int GW = PER_W + 1;

  logic [SYNC_STAGES-1:0] sync_sr;
  logic                   s_in;
  logic [HW-1:0]          hi_cnt;
  logic                   blocked, start_blk, qual, faster;
  logic [GW-1:0]          gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_sr <= '0;
    else        sync_sr <= {sync_sr[SYNC_STAGES-2:0], sync_in};
  end
  assign s_in = sync_sr[SYNC_STAGES-1];

  // Width qualification and own-drive blocking.
  assign start_blk = s_in && (hi_cnt == '0) && drive_active;
  assign qual      = s_in && (hi_cnt == HW'(IN_MIN_PW - 1)) && !blocked && !start_blk;

  always_ff @(posedge clk) begin
    if (!rst_n || !s_in) begin
      hi_cnt  <= '0;
      blocked <= 1'b0;
    end else begin
      if (hi_cnt != HW'(IN_MIN_PW)) hi_cnt <= hi_cnt + 1'b1;
      if (start_blk)                blocked <= 1'b1;
    end
  end

  // Interval since previous accepted-width pulse, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n)             gap_cnt <= '1;
    else if (qual)          gap_cnt <= GW'(1);
    else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
  end

  assign faster     = (gap_cnt < {1'b0, period_q});
  assign ext_accept = qual && faster;

  always_ff @(posedge clk) begin
    if (!rst_n)
      slave_mode <= 1'b0;
    else if (ext_accept)
      slave_mode <= 1'b1;
    else if (slave_mode && (gap_cnt >= {1'b0, period_q}))
      slave_mode <= 1'b0;
  end
endmodule

// File: rtl/pwmsync_clk_unit.sv
`timescale 1ns/1ps
module pwmsync_clk_unit #(
  parameter int PIN_W       = 12,
  parameter int DEF_PERIOD  = 1000,
  parameter int MIN_PERIOD  = 250,
  parameter int OUT_PW      = 28,
  parameter int IN_MIN_PW   = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] period_in,
  input  logic             period_load,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             sync_oe,
  output logic             cycle_start,
  output logic             slave_mode
);
  localparam int PER_W = $clog2(DEF_PERIOD + 1);

  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] cnt_w;
  logic [PER_W-1:0] half_w;
  logic             ext_accept;
  logic             drive_active;

  pwmsync_period_reg #(
    .PIN_W(PIN_W), .PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD), .MIN_PERIOD(MIN_PERIOD)
  ) per_i (
    .clk(clk), .rst_n(rst_n), .load(period_load), .period_in(period_in), .period_q(period_q)
  );

  pwmsync_cycle_timer #(.PER_W(PER_W), .OUT_PW(OUT_PW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .period_q(period_q), .ext_accept(ext_accept),
    .slave_mode(slave_mode), .cnt(cnt_w), .half(half_w),
    .cycle_start(cycle_start), .drive_active(drive_active)
  );

  pwmsync_ext_detect #(
    .PER_W(PER_W), .IN_MIN_PW(IN_MIN_PW), .SYNC_STAGES(SYNC_STAGES)
  ) det_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .drive_active(drive_active),
    .period_q(period_q), .ext_accept(ext_accept), .slave_mode(slave_mode)
  );

  assign sync_out = drive_active && !slave_mode;
  assign sync_oe  = !slave_mode;
endmodule

// File: rtl/pwmsync_clk_unit_chk.sv
`timescale 1ns/1ps
module pwmsync_clk_unit_chk #(
  parameter int PER_W      = 10,
  parameter int DEF_PERIOD = 1000,
  parameter int MIN_PERIOD = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cycle_start,
  input logic             sync_out,
  input logic             sync_oe,
  input logic             slave_mode,
  input logic             ext_accept,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] half,
  input logic [PER_W-1:0] period_q
);
  AST_CS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> cnt == '0); // R2

  AST_SYNC_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) && $stable(period_q) |-> cnt == half); // R3

  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(period_q) >= MIN_PERIOD) && (32'(period_q) <= DEF_PERIOD)); // R4

  AST_ACCEPT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ext_accept |=> cycle_start && cnt == '0); // R5

  AST_SLAVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_mode) |-> $past(ext_accept)); // R5

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !sync_oe && !sync_out); // R7
endmodule

bind pwmsync_clk_unit pwmsync_clk_unit_chk #(
  .PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD), .MIN_PERIOD(MIN_PERIOD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .sync_out(sync_out),
  .sync_oe(sync_oe), .slave_mode(slave_mode), .ext_accept(ext_accept),
  .cnt(cnt_w), .half(half_w), .period_q(period_q)
);

// File: tb/pwmsync_clk_unit_tb_top.sv
`timescale 1ns/1ps
module pwmsync_clk_unit_tb_top;
  localparam int IPW = 18;
  localparam int OPW = 28;
  localparam int LAT = IPW + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [11:0] per_in_a = '0, per_in_b = '0;
  logic        per_ld_a = 1'b0, per_ld_b = 1'b0;
  logic        ext_drv = 1'b0, share = 1'b0;
  logic        out_a, oe_a, cs_a, slv_a, out_b, oe_b, cs_b, slv_b;
  logic        line;

  assign line = (oe_a & out_a) | ext_drv | (share & oe_b & out_b);

  pwmsync_clk_unit dut_i (
    .clk(clk), .rst_n(rst_n), .period_in(per_in_a), .period_load(per_ld_a),
    .sync_in(line), .sync_out(out_a), .sync_oe(oe_a), .cycle_start(cs_a), .slave_mode(slv_a)
  );

  pwmsync_clk_unit peer_i (
    .clk(clk), .rst_n(rst_n), .period_in(per_in_b), .period_load(per_ld_b),
    .sync_in(share & line), .sync_out(out_b), .sync_oe(oe_b), .cycle_start(cs_b), .slave_mode(slv_b)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  logic train_busy = 1'b0;

  typedef struct {int val; string req;} exp_t;
  exp_t q_gap[$], q_ofs[$], q_wid[$], q_lat[$], q_ph[$];

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver side of the scoreboard: 0 gap, 1 offset, 2 width, 3 latency, 4 phase.
  task automatic push(int kind, int v, string req, int n);
    exp_t e;
    e.val = v; e.req = req;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: q_gap.push_back(e);
        1: q_ofs.push_back(e);
        2: q_wid.push_back(e);
        3: q_lat.push_back(e);
        default: q_ph.push_back(e);
      endcase
    end
  endtask

  // Monitor side: measure events and pop matching expectations.
  int   last_cs = -1, last_pcs = -1, so_rise = -1, last_ext = -100000;
  logic so_prev = 1'b0;
  exp_t m_e;
  always @(negedge clk) begin
    if (cs_b) last_pcs = cyc;
    if (cs_a) begin
      if (last_cs >= 0 && q_gap.size() > 0) begin
        m_e = q_gap.pop_front(); chk(m_e.req, "cycle gap", cyc - last_cs, m_e.val);
      end
      if (q_lat.size() > 0) begin
        m_e = q_lat.pop_front(); chk(m_e.req, "ext latency", cyc - last_ext, m_e.val);
      end
      if (q_ph.size() > 0) begin
        m_e = q_ph.pop_front(); chk(m_e.req, "peer phase", cyc - last_pcs, m_e.val);
      end
      last_cs = cyc;
    end
    if (out_a && !so_prev) begin
      so_rise = cyc;
      if (q_ofs.size() > 0) begin
        m_e = q_ofs.pop_front(); chk(m_e.req, "sync offset", cyc - last_cs, m_e.val);
      end
    end
    if (!out_a && so_prev && q_wid.size() > 0) begin
      m_e = q_wid.pop_front(); chk(m_e.req, "sync width", cyc - so_rise, m_e.val);
    end
    so_prev = out_a;
  end

  task automatic drain();
    while (q_gap.size() + q_ofs.size() + q_wid.size() + q_lat.size() + q_ph.size() > 0)
      @(negedge clk);
  endtask

  task automatic wait_cs();
    @(negedge clk);
    while (!cs_a) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic ext_pulse(int width);
    @(negedge clk);
    ext_drv = 1'b1;
    last_ext = cyc;
    repeat (width) @(negedge clk);
    ext_drv = 1'b0;
  endtask

  task automatic ext_train(int interval, int width, int n);
    train_busy = 1'b1;
    for (int i = 0; i < n; i++) begin
      ext_pulse(width);
      repeat (interval - width - 1) @(negedge clk);
    end
    train_busy = 1'b0;
  endtask

  task automatic wait_train();
    @(negedge clk);
    while (train_busy) @(negedge clk);
  endtask

  task automatic load_a(int v);
    @(negedge clk);
    per_in_a = 12'(v); per_ld_a = 1'b1;
    @(negedge clk);
    per_ld_a = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc == 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=finished earlier", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (5) @(negedge clk);
    chk("R1", "cycle_start in reset", int'(cs_a), 0);
    chk("R1", "sync_out in reset", int'(out_a), 0);
    chk("R1", "sync_oe in reset", int'(oe_a), 1);
    chk("R1", "slave_mode in reset", int'(slv_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "slave_mode after reset", int'(slv_a), 0);

    // R2, R3 default period and mid-cycle pulse
    wait_cs();
    push(0, 1000, "R2", 3);
    push(1, 500, "R3", 2);
    push(2, OPW, "R3", 2);
    drain();
    chk("R3", "sync_oe master", int'(oe_a), 1);

    // R4 period programming with clamp
    load_a(400);
    wait_cs(); wait_cs();
    push(0, 400, "R4", 2); push(1, 200, "R4", 2);
    drain();
    load_a(100);
    wait_cs(); wait_cs();
    push(0, 250, "R4", 2); push(1, 125, "R4", 2);
    drain();
    load_a(3000);
    wait_cs(); wait_cs();
    push(0, 1000, "R4", 2); push(1, 500, "R4", 1);
    drain();

    // R5, R8 faster train of minimum-width pulses takes over
    fork ext_train(600, IPW, 8); join_none
    @(negedge clk);
    while (!slv_a) @(negedge clk);
    wait_cs();
    chk("R7", "sync_oe in slave", int'(oe_a), 0);
    push(0, 600, "R5", 3); push(3, LAT, "R5", 3);
    drain();
    chk("R8", "min-width pulses accepted", int'(slv_a), 1);
    chk("R7", "sync_out in slave", int'(out_a), 0);
    wait_train();

    // R7 release after external train stops
    repeat (1100) @(negedge clk);
    chk("R7", "slave released", int'(slv_a), 0);
    chk("R7", "sync_oe restored", int'(oe_a), 1);
    wait_cs();
    push(0, 1000, "R7", 2);
    drain();

    // R6 slower train ignored
    fork ext_train(1500, IPW + 2, 5); join_none
    wait_cs();
    push(0, 1000, "R6", 4);
    drain();
    chk("R6", "stays master on slow train", int'(slv_a), 0);
    wait_train();

    // R8 narrow fast pulses ignored
    fork ext_train(600, IPW - 1, 6); join_none
    wait_cs();
    push(0, 1000, "R8", 3);
    drain();
    chk("R8", "narrow pulses ignored", int'(slv_a), 0);
    wait_train();
    repeat (1200) @(negedge clk);

    // R9 own pulse on the line is not a rate reference
    @(negedge clk);
    while (!out_a) @(negedge clk);
    repeat (300) @(negedge clk);
    ext_pulse(IPW + 2);
    repeat (40) @(negedge clk);
    chk("R9", "own pulse not counted", int'(slv_a), 0);
    wait_cs();
    push(0, 1000, "R9", 2);
    drain();

    // R10 two units on one line
    @(negedge clk);
    per_in_b = 12'd500; per_ld_b = 1'b1; share = 1'b1;
    @(negedge clk);
    per_ld_b = 1'b0;
    while (!slv_a) @(negedge clk);
    wait_cs(); wait_cs();
    push(0, 500, "R10", 3); push(4, 250 + LAT, "R10", 3);
    drain();
    chk("R10", "faster unit stays master", int'(slv_b), 0);
    chk("R10", "slower unit driver off", int'(oe_a), 0);
    chk("R10", "faster unit drives", int'(oe_b), 1);

    summary();
    $finish;
  end
endmodule